// File: doc/BRIEF.md
# Per-Core Watchdog Policy Register Bank

This block holds the software-visible policy state for a set of watchdog timers, one per processor core. Each core owns a 32-byte window in a small register space. Each window has a control/status word and a read-only locator word. A simple bus reaches the bank: write enable, read enable, byte offset, write data, byte strobes and registered read data. The bank sends a pause level to each core's timer and an enable that allows that core to be reset on a second expiry. The timer and the reset logic are not part of this block.

Software pauses a timer only by writing a fixed 8-bit key. It resumes the timer by writing a one to the paused flag. It can set the second-expiry reset enable but cannot clear it. The enable drops only when that core's power-active input goes low. The locator word gives each core's timer register base and a version number.

Top module: `wdt_policy_bank`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, every `pause_o` and `store_en_o` bit and `bus_rdata` are 0.
- R2: A write to core c's control word (window offset 0x04) with strobe bit 0 set and data bits 7:0 equal to 0x76 sets core c's paused flag. Any other value, or strobe bit 0 clear, leaves the flag unchanged. Bits 7:0 always read back as 0.
- R3: A control write with strobe bit 1 and data bit 8 set clears the paused flag. Data bit 8 at 0 leaves the flag unchanged. If the same write also carries the key, the flag ends at 0. `pause_o[c]` equals the flag. The flag reads back at bit 8.
- R4: A control write with strobe bit 1 and data bit 9 set sets the reset-enable flag. Data bit 9 at 0 never clears it. `store_en_o[c]` equals the flag. The flag reads back at bit 9.
- R5: In any cycle where `pwr_active_i[c]` is 0, core c's reset-enable flag is cleared at the clock edge. This takes priority over a software set in the same cycle.
- R6: The locator word (window offset 0x08) reads 0x78300 + 0x100·c in bits 20:0 and 0 in bits 23:21. Writes to it have no effect.
- R7: Unused bits read 0. Reads of any other offset, of a core index at or above NUM_CORES, or of an address not aligned to 4 return 0. Writes to any of these change no state.
- R8: A write to one core's window changes no other core's flags.
- R9: `bus_rdata` is valid one clock after a cycle with `bus_rd_en` high and shows the state before any write in that same cycle. It is 0 after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write request this cycle |
| bus_rd_en | input | 1 | Read request this cycle |
| bus_addr | input | ADDR_W | Byte offset into the bank |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte lane enables for writes |
| bus_rdata | output | 32 | Registered read data |
| pwr_active_i | input | NUM_CORES | Per-core power-active level |
| pause_o | output | NUM_CORES | Per-core timer pause |
| store_en_o | output | NUM_CORES | Per-core second-expiry reset enable |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the pause key and the clear bit, when both arrive in one control write. The second pair is the power-loss clear and a software set of the reset enable. Directed writes provoke the first pair by carrying 0x76 and bit 8 together. They provoke the second by holding a core's power input low while writing bit 9. Randomized traffic then mixes keys, flag bits, strobes and power toggles freely. A bench model judges each cycle by letting the clear win in both cases, and it compares the outputs and read data on every cycle.

// File: rtl/wdt_bank_pkg.sv
package wdt_bank_pkg;
  localparam int DATA_W    = 32;
  localparam int STRB_W    = DATA_W / 8;
  localparam int WIN_SHIFT = 5;              // 32-byte window per core
  localparam int WORD_W    = WIN_SHIFT - 2;  // word index inside a window

  localparam logic [WORD_W-1:0] WORD_CTRL = 3'd1;   // byte offset 0x04
  localparam logic [WORD_W-1:0] WORD_LOC  = 3'd2;   // byte offset 0x08

  localparam logic [7:0]  PAUSE_KEY = 8'h76;
  localparam int          KEY_LSB   = 0;
  localparam int          PAUSE_BIT = 8;
  localparam int          STORE_BIT = 9;

  localparam int          LOC_W     = 21;
  localparam int          VER_W     = 3;
  localparam logic [LOC_W-1:0] LOC_BASE = 21'h78300;
  localparam logic [LOC_W-1:0] LOC_STEP = 21'h00100;
  localparam logic [VER_W-1:0] IP_VER   = 3'd0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LOC  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic set_pause;
    logic clr_pause;
    logic set_store;
  } ctrl_cmd_t;
endpackage

// File: rtl/wdt_addr_decode.sv
module wdt_addr_decode
  import wdt_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  localparam int IDX_W    = ADDR_W - WIN_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  core_idx,
  output reg_sel_e          sel,
  output logic              hit
);
  localparam logic [IDX_W:0] CORE_LIMIT = (IDX_W+1)'(NUM_CORES);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              in_range;

  always_comb begin
    core_idx = addr[ADDR_W-1:WIN_SHIFT];
    word     = addr[WIN_SHIFT-1:2];
    aligned  = (addr[1:0] == 2'b00);
    in_range = ({1'b0, core_idx} < CORE_LIMIT);
    if (!aligned || !in_range)  sel = SEL_NONE;
    else if (word == WORD_CTRL) sel = SEL_CTRL;
    else if (word == WORD_LOC)  sel = SEL_LOC;
    else                        sel = SEL_NONE;
    hit = (sel != SEL_NONE);
  end
endmodule

// File: rtl/wdt_core_regs.sv
module wdt_core_regs
  import wdt_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ctrl_cmd_t cmd,
  input  logic      pwr_active,
  output logic      paused,
  output logic      store_en
);
  // clear beats the key on a combined write
  always_ff @(posedge clk) begin
    if (rst) begin
      paused <= 1'b0;
    end else if (cmd.clr_pause) begin
      paused <= 1'b0;
    end else if (cmd.set_pause) begin
      paused <= 1'b1;
    end
  end

  // loss of power beats a software set
  always_ff @(posedge clk) begin
    if (rst) begin
      store_en <= 1'b0;
    end else if (!pwr_active) begin
      store_en <= 1'b0;
    end else if (cmd.set_store) begin
      store_en <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_read_mux.sv
module wdt_read_mux
  import wdt_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 5
) (
  input  logic [IDX_W-1:0]     core_idx,
  input  reg_sel_e             sel,
  input  logic [NUM_CORES-1:0] paused,
  input  logic [NUM_CORES-1:0] store_en,
  output logic [DATA_W-1:0]    word
);
  logic             cur_pause;
  logic             cur_store;
  logic [LOC_W-1:0] loc;

  always_comb begin
    cur_pause = 1'b0;
    cur_store = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (core_idx == IDX_W'(c)) begin
        cur_pause = paused[c];
        cur_store = store_en[c];
      end
    end
    loc  = LOC_BASE + LOC_STEP * LOC_W'(core_idx);
    word = '0;
    case (sel)
      SEL_CTRL: begin
        word[PAUSE_BIT] = cur_pause;
        word[STORE_BIT] = cur_store;
      end
      SEL_LOC: begin
        word[LOC_W-1:0]           = loc;
        word[LOC_W+VER_W-1:LOC_W] = IP_VER;
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/wdt_policy_bank.sv
module wdt_policy_bank
  import wdt_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_wstrb,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_CORES-1:0] pwr_active_i,
  output logic [NUM_CORES-1:0] pause_o,
  output logic [NUM_CORES-1:0] store_en_o
);
  localparam int IDX_W = ADDR_W - WIN_SHIFT;

  logic [IDX_W-1:0]  core_idx;
  reg_sel_e          sel;
  logic              hit;
  logic              ctrl_wr;
  ctrl_cmd_t         base_cmd;
  logic [DATA_W-1:0] rd_word;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[DATA_W-1:STORE_BIT+1], bus_wstrb[STRB_W-1:2]};

  wdt_addr_decode #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .addr     (bus_addr),
    .core_idx (core_idx),
    .sel      (sel),
    .hit      (hit)
  );

  always_comb begin
    ctrl_wr            = bus_wr_en && hit && (sel == SEL_CTRL);
    base_cmd.set_pause = bus_wstrb[0] && (bus_wdata[KEY_LSB+7:KEY_LSB] == PAUSE_KEY);
    base_cmd.clr_pause = bus_wstrb[1] && bus_wdata[PAUSE_BIT];
    base_cmd.set_store = bus_wstrb[1] && bus_wdata[STORE_BIT];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ctrl_cmd_t core_cmd;
    logic      mine;

    assign mine     = ctrl_wr && (core_idx == IDX_W'(c));
    assign core_cmd = mine ? base_cmd : '0;

    wdt_core_regs u_regs (
      .clk        (clk),
      .rst        (rst),
      .cmd        (core_cmd),
      .pwr_active (pwr_active_i[c]),
      .paused     (pause_o[c]),
      .store_en   (store_en_o[c])
    );
  end

  wdt_read_mux #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W)
  ) u_rmux (
    .core_idx (core_idx),
    .sel      (sel),
    .paused   (pause_o),
    .store_en (store_en_o),
    .word     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_word;
    else                bus_rdata <= '0;
  end
endmodule

// File: rtl/wdt_policy_bank_chk.sv
module wdt_policy_bank_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr_en,
  input logic                 bus_rd_en,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [3:0]           bus_wstrb,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CORES-1:0] pwr_active_i,
  input logic [NUM_CORES-1:0] pause_o,
  input logic [NUM_CORES-1:0] store_en_o
);
  logic [ADDR_W-1:0] addr_seen;
  assign addr_seen = bus_addr;

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pause_o == '0 && store_en_o == '0 && bus_rdata == '0));

  assert_pause_rise_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
    ((pause_o & ~$past(pause_o)) != '0) |->
      $past(bus_wr_en && bus_wstrb[0] && bus_wdata[7:0] == 8'h76));

  assert_pause_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ((~pause_o & $past(pause_o)) != '0) |->
      $past(bus_wr_en && bus_wstrb[1] && bus_wdata[8]));

  assert_store_rise_needs_set_R4: assert property (@(posedge clk) disable iff (rst)
    ((store_en_o & ~$past(store_en_o)) != '0) |->
      $past(bus_wr_en && bus_wstrb[1] && bus_wdata[9]));

  assert_power_clears_store_R5: assert property (@(posedge clk) disable iff (rst)
    ((store_en_o & ~$past(pwr_active_i)) == '0));

  assert_one_core_per_write_R8: assert property (@(posedge clk) disable iff (rst)
    ($countones(pause_o ^ $past(pause_o)) <= 1));

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd_en) |-> (bus_rdata == '0));

  assert_no_pause_change_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr_en) |-> $stable(pause_o));
endmodule

bind wdt_policy_bank wdt_policy_bank_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr_en    (bus_wr_en),
  .bus_rd_en    (bus_rd_en),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_wstrb    (bus_wstrb),
  .bus_rdata    (bus_rdata),
  .pwr_active_i (pwr_active_i),
  .pause_o      (pause_o),
  .store_en_o   (store_en_o)
);

// File: tb/wdt_policy_bank_bench.sv
`timescale 1ns/1ps
module wdt_policy_bank_bench;
  localparam int NC = 4;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [3:0]    wstrb = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] pwr = '1;
  logic [NC-1:0] pause;
  logic [NC-1:0] store;

  logic [NC-1:0] mp = '0;
  logic [NC-1:0] ms = '0;
  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_policy_bank #(.NUM_CORES(NC), .ADDR_W(AW)) u_wdt_policy_bank (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_wstrb(wstrb), .bus_rdata(rdata),
    .pwr_active_i(pwr), .pause_o(pause), .store_en_o(store));

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    int idx = int'(a >> 5);
    logic [2:0] w = a[4:2];
    logic [31:0] r = '0;
    if (a[1:0] != 2'b00 || idx >= NC) return '0;
    if (w == 3'd1) begin r[8] = mp[idx]; r[9] = ms[idx]; end
    else if (w == 3'd2) r[20:0] = 21'h78300 + 21'h100 * 21'(idx);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: model advances with the same inputs the design sees
  task automatic tick(string tag);
    logic [31:0] exp_rd;
    int idx;
    exp_rd = rd_en ? model_read(addr) : 32'h0;
    @(posedge clk);
    idx = int'(addr >> 5);
    if (wr_en && addr[1:0] == 2'b00 && addr[4:2] == 3'd1 && idx < NC) begin
      if (wstrb[0] && wdata[7:0] == 8'h76) mp[idx] = 1'b1;
      if (wstrb[1] && wdata[8]) mp[idx] = 1'b0;
      if (wstrb[1] && wdata[9]) ms[idx] = 1'b1;
    end
    for (int c = 0; c < NC; c++) if (!pwr[c]) ms[c] = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check({tag, " rdata"}, rdata, exp_rd);
    check({tag, " pause"}, 32'(pause), 32'(mp));
    check({tag, " store"}, 32'(store), 32'(ms));
  endtask

  task automatic wr(string tag, logic [AW-1:0] a, logic [31:0] d, logic [3:0] s);
    wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
    tick(tag);
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    rd_en = 1'b1; addr = a;
    tick(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // reset, with a read pending to prove rdata is held at 0
    wr_en = 1'b1; addr = 10'h004; wdata = 32'h0000_0376; wstrb = 4'hF;
    rd_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pause", 32'(pause), 0);
    check("R1 reset store", 32'(store), 0);
    check("R1 reset rdata", rdata, 0);
    rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    tick("R1 idle");

    // R2 key sets pause, others do not, byte 0 reads 0
    wr("R2 wrong key", 10'h004, 32'h0000_0075, 4'h1);
    wr("R2 key no strobe", 10'h004, 32'h0000_0076, 4'h2);
    wr("R2 key", 10'h004, 32'h0000_0076, 4'h1);
    rd("R2 readback", 10'h004);
    // R3 write 0 keeps, write 1 clears, combined key+clear clears
    wr("R3 zero keeps", 10'h004, 32'h0000_0000, 4'hF);
    wr("R3 clear", 10'h004, 32'h0000_0100, 4'h2);
    wr("R3 key again", 10'h024, 32'h0000_0076, 4'h1);
    wr("R3 key plus clear", 10'h024, 32'h0000_0176, 4'h3);
    rd("R3 readback", 10'h024);
    // R4 set, write 0 does not clear
    wr("R4 set", 10'h044, 32'h0000_0200, 4'h2);
    wr("R4 zero keeps", 10'h044, 32'h0000_0000, 4'hF);
    rd("R4 readback", 10'h044);
    // R5 power low clears, and beats a simultaneous set
    pwr[2] = 1'b0;
    tick("R5 power clear");
    wr("R5 set while off", 10'h044, 32'h0000_0200, 4'h2);
    pwr[2] = 1'b1;
    wr("R5 set after on", 10'h044, 32'h0000_0200, 4'h2);
    // R6 locator per core, writes ignored
    for (int c = 0; c < NC; c++) rd("R6 locator", AW'(c * 32 + 8));
    wr("R6 write locator", 10'h068, 32'hFFFF_FFFF, 4'hF);
    rd("R6 locator after write", 10'h068);
    // R7 unmapped, out of range, misaligned
    rd("R7 offset 0", 10'h000);
    rd("R7 offset 0x0C", 10'h00C);
    rd("R7 core 4", 10'h084);
    rd("R7 misaligned", 10'h005);
    wr("R7 write core 4", 10'h084, 32'h0000_0276, 4'hF);
    wr("R7 write misaligned", 10'h065, 32'h0000_0276, 4'hF);
    wr("R7 write other word", 10'h070, 32'h0000_0276, 4'hF);
    // R8 isolation
    wr("R8 core3 key", 10'h064, 32'h0000_0276, 4'h3);
    rd("R8 core1 untouched", 10'h024);
    // R9 read sees pre-write state
    wr_en = 1'b1; rd_en = 1'b1; addr = 10'h064; wdata = 32'h0000_0100; wstrb = 4'h2;
    tick("R9 read with write");
    rd("R9 after", 10'h064);

    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom % 8);
      logic [AW-1:0] a;
      logic [31:0] d;
      a = AW'((($urandom % 5) << 5) | (($urandom % 4) << 2));
      if ($urandom % 16 == 0) a = AW'($urandom);
      d = $urandom;
      if ($urandom % 2 == 0) d[7:0] = 8'h76;
      if ($urandom % 8 == 0) pwr[$urandom % NC] ^= 1'b1;
      if (op < 4) begin wr_en = 1'b1; addr = a; wdata = d; wstrb = 4'($urandom); end
      if (op >= 2 && op < 6) begin rd_en = 1'b1; addr = a; end
      tick("R8 R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule